// File: doc/BRIEF.md
# Multi-lane serial flash command receiver

This block is the target-side command front end for the register interface of a serial flash device. While chip select is low it shifts in a command byte and, for some commands, an address and a data byte. It samples one, two or four data lines on each rising clock edge, as set by the protocol mode input. It recognises two commands. The first writes a one-byte lock register. The second clears three sticky error flags: erase, program and protection. Other command codes leave all state unchanged.

Neither command acts while it is being shifted in. The block applies a command on the first clock edge at which chip select is sampled high again. The lock write is a write-type command, so it takes effect only when chip select rises right after the last data bit. A frame with one clock too few or too many is dropped, and the write-enable latch stays set. The flag clear only needs its opcode to be complete. After that, chip select may rise on any clock.

Two test inputs drive the block from outside. One sets the write-enable latch and the other sets the error flags. The lock register, the flags and the latch are plain outputs. Data arrives as a raw clocked serial stream paced by chip select, so the block has no valid/ready handshake. The mode input must stay constant while chip select is low.

Top module: `sflash_cmd_rx`

## Requirements
- R1: Mode encoding: mode 0 (and reserved 3) takes 1 bit per clock from dq[0]. Mode 1 takes 2 bits from dq[1:0]. Mode 2 takes 4 bits from dq[3:0]. Higher-numbered lines carry the earlier (more significant) bits, and every field is sent MSB first.
- R2: A lock write is opcode 0xE5, then 24 address bits, then one data byte: 40 bits in all. That is 40, 20 or 10 clocks in modes 0, 1 and 2. If chip select is sampled high right after exactly that many clocks and the write-enable latch is 1, lock_reg takes the data byte on that edge.
- R3: A lock write of any other clock count is dropped. lock_reg, flags and wel keep their values, so wel stays 1.
- R4: A complete lock write is ignored while wel is 0.
- R5: A committed lock write clears wel.
- R6: Opcode 0x50 clears all three flags when chip select rises at any point after the opcode is complete, even after extra clocks.
- R7: A selection that ends before the 8 opcode bits are in has no effect.
- R8: Each bit of err_set sets the matching flag. The flags are sticky. Bit 0 is erase, bit 1 is program and bit 2 is protection. A set in the same cycle as a clear wins.
- R9: A pulse on wren_set sets wel, and it wins over a clear by a commit in the same cycle.
- R10: After reset, lock_reg is 0x00, flags is 000 and wel is 0.
- R11: Any other opcode leaves lock_reg, flags and wel unchanged, whatever the frame length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; inputs sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| mode | input | 2 | Protocol mode: 0 single, 1 dual, 2 quad, 3 single |
| dq | input | 4 | Serial data lines |
| wren_set | input | 1 | Test input: sets the write-enable latch |
| err_set | input | 3 | Test input: sets error flags (0 erase, 1 program, 2 protection) |
| lock_reg | output | 8 | Lock register contents |
| flags | output | 3 | Sticky error flags |
| wel | output | 1 | Write-enable latch |

## Verification
A bit counter that is off by one lane width shows up in the first frame that ends on the boundary. The legal lock write is then dropped: lock_reg keeps its old value and wel stays 1. The short or long variant commits instead and changes lock_reg. Either way the error is visible one clock after chip select rises. A wrong lane order or a wrong opcode capture gives a wrong lock byte, or the flags fail to clear, at that same edge. A latch or flag that changes while chip select is low breaks the rule that state changes only after a deselect. That rule is checked on every clock.

// File: rtl/sfcr_pkg.sv
package sfcr_pkg;
  typedef enum logic [1:0] {
    MODE_X1   = 2'd0,
    MODE_X2   = 2'd1,
    MODE_X4   = 2'd2,
    MODE_RSVD = 2'd3
  } lane_mode_e;

  localparam logic [7:0] OPC_LOCK_WR   = 8'hE5;
  localparam logic [7:0] OPC_FLAG_CLR  = 8'h50;
  localparam int         NUM_ERR_FLAGS = 3;
endpackage

// File: rtl/sfcr_shift.sv
module sfcr_shift
  import sfcr_pkg::*;
#(
  parameter int OP_BITS    = 8,
  parameter int DATA_BITS  = 8,
  parameter int FRAME_BITS = 40,
  parameter int CW         = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic [1:0]           mode,
  input  logic [3:0]           dq,
  output logic [DATA_BITS-1:0] tail_byte,
  output logic [OP_BITS-1:0]   opcode,
  output logic [CW-1:0]        bit_cnt,
  output logic                 deselect
);
  logic [DATA_BITS-1:0] sr_q, sr_nxt;
  logic [OP_BITS-1:0]   op_q;
  logic [CW-1:0]        cnt_q, cnt_nxt, step;
  logic                 cs_q;
  lane_mode_e           lm;

  assign lm = lane_mode_e'(mode);

  always_comb begin
    case (lm)
      MODE_X2: begin
        step   = CW'(2);
        sr_nxt = {sr_q[DATA_BITS-3:0], dq[1:0]};
      end
      MODE_X4: begin
        step   = CW'(4);
        sr_nxt = {sr_q[DATA_BITS-5:0], dq[3:0]};
      end
      default: begin
        step   = CW'(1);
        sr_nxt = {sr_q[DATA_BITS-2:0], dq[0]};
      end
    endcase
  end

  // saturate once the frame has been overrun; exact count no longer matters
  assign cnt_nxt = (cnt_q > CW'(FRAME_BITS)) ? cnt_q : cnt_q + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      op_q  <= '0;
      cnt_q <= '0;
      cs_q  <= 1'b1;
    end else begin
      cs_q <= cs_n;
      if (cs_n) begin
        cnt_q <= '0;
      end else begin
        sr_q  <= sr_nxt;
        cnt_q <= cnt_nxt;
        if (cnt_q < CW'(OP_BITS) && (cnt_q + step) == CW'(OP_BITS))
          op_q <= sr_nxt[OP_BITS-1:0];
      end
    end
  end

  assign tail_byte = sr_q;
  assign opcode    = op_q;
  assign bit_cnt   = cnt_q;
  assign deselect  = cs_n & ~cs_q;
endmodule

// File: rtl/sfcr_decode.sv
module sfcr_decode
  import sfcr_pkg::*;
#(
  parameter int OP_BITS    = 8,
  parameter int FRAME_BITS = 40,
  parameter int CW         = 6
) (
  input  logic               deselect,
  input  logic [OP_BITS-1:0] opcode,
  input  logic [CW-1:0]      bit_cnt,
  output logic               lock_go,
  output logic               clr_go
);
  logic op_done, frame_exact;

  assign op_done     = bit_cnt >= CW'(OP_BITS);
  assign frame_exact = bit_cnt == CW'(FRAME_BITS);

  // write-type command: only an exact end of frame commits
  assign lock_go = deselect && frame_exact && (opcode == OPC_LOCK_WR);
  // clear command: any end after the opcode is complete
  assign clr_go  = deselect && op_done && (opcode == OPC_FLAG_CLR);
endmodule

// File: rtl/sfcr_regs.sv
module sfcr_regs #(
  parameter int DATA_BITS = 8,
  parameter int NFLAG     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lock_go,
  input  logic                 clr_go,
  input  logic [DATA_BITS-1:0] wr_data,
  input  logic                 wren_set,
  input  logic [NFLAG-1:0]     err_set,
  output logic [DATA_BITS-1:0] lock_q,
  output logic [NFLAG-1:0]     flag_q,
  output logic                 wel_q
);
  logic commit;

  assign commit = lock_go & wel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      wel_q  <= 1'b0;
    end else begin
      if (commit) lock_q <= wr_data;
      if (wren_set)    wel_q <= 1'b1;
      else if (commit) wel_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[g] <= 1'b0;
      else if (err_set[g]) flag_q[g] <= 1'b1;
      else if (clr_go)     flag_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/sflash_cmd_rx.sv
module sflash_cmd_rx
  import sfcr_pkg::*;
#(
  parameter int OP_BITS   = 8,
  parameter int ADDR_BITS = 24,
  parameter int DATA_BITS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic [1:0]               mode,
  input  logic [3:0]               dq,
  input  logic                     wren_set,
  input  logic [NUM_ERR_FLAGS-1:0] err_set,
  output logic [DATA_BITS-1:0]     lock_reg,
  output logic [NUM_ERR_FLAGS-1:0] flags,
  output logic                     wel
);
  localparam int FRAME_BITS = OP_BITS + ADDR_BITS + DATA_BITS;
  localparam int CW         = $clog2(FRAME_BITS + 5);

  logic [DATA_BITS-1:0] tail_byte;
  logic [OP_BITS-1:0]   opcode;
  logic [CW-1:0]        bit_cnt;
  logic                 deselect, lock_go, clr_go;

  sfcr_shift #(
    .OP_BITS(OP_BITS), .DATA_BITS(DATA_BITS),
    .FRAME_BITS(FRAME_BITS), .CW(CW)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mode(mode), .dq(dq),
    .tail_byte(tail_byte), .opcode(opcode), .bit_cnt(bit_cnt),
    .deselect(deselect)
  );

  sfcr_decode #(
    .OP_BITS(OP_BITS), .FRAME_BITS(FRAME_BITS), .CW(CW)
  ) u_dec (
    .deselect(deselect), .opcode(opcode), .bit_cnt(bit_cnt),
    .lock_go(lock_go), .clr_go(clr_go)
  );

  sfcr_regs #(
    .DATA_BITS(DATA_BITS), .NFLAG(NUM_ERR_FLAGS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .lock_go(lock_go), .clr_go(clr_go),
    .wr_data(tail_byte), .wren_set(wren_set), .err_set(err_set),
    .lock_q(lock_reg), .flag_q(flags), .wel_q(wel)
  );
endmodule

// File: rtl/sflash_cmd_rx_chk.sv
module sflash_cmd_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       wren_set,
  input logic [2:0] err_set,
  input logic [7:0] lock_reg,
  input logic [2:0] flags,
  input logic       wel
);
  AST_LOCK_ONLY_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock_reg) |-> $past(cs_n)); // R2

  AST_LOCK_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock_reg) |-> $past(wel)); // R4

  AST_WEL_DROP_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wel) |-> ($past(cs_n) && !$past(wren_set))); // R5

  AST_FLAG_CLEAR_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(flags) < $countones($past(flags))) |-> $past(cs_n)); // R6

  AST_FLAG_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set != 3'b000) |=> ((flags & $past(err_set)) == $past(err_set))); // R8

  AST_WREN_SETS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    wren_set |=> wel); // R9
endmodule

bind sflash_cmd_rx sflash_cmd_rx_chk u_chk (.*);

// File: tb/sflash_cmd_rx_test.sv
module sflash_cmd_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [3:0] dq = 4'h0;
  logic       wren_set = 1'b0;
  logic [2:0] err_set = 3'b000;
  logic [7:0] lock_reg;
  logic [2:0] flags;
  logic       wel;

  int applied = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [7:0] m_lock  = 8'h00;
  logic [2:0] m_flags = 3'b000;
  logic       m_wel   = 1'b0;

  logic [11:0] exp_q[$];
  string       tag_q[$];
  event        chk_ev;

  always #5 clk = ~clk;

  sflash_cmd_rx uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mode(mode), .dq(dq),
    .wren_set(wren_set), .err_set(err_set),
    .lock_reg(lock_reg), .flags(flags), .wel(wel)
  );

  // monitor: compares observed state against scoreboard entries
  initial begin
    forever begin
      @(chk_ev);
      #1;
      while (exp_q.size() > 0) begin
        logic [11:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        applied++;
        if ({lock_reg, flags, wel} !== e) begin
          errors++;
          $display("FAIL %s: lock=%h flags=%b wel=%b expected lock=%h flags=%b wel=%b",
                   t, lock_reg, flags, wel, e[11:4], e[3:1], e[0]);
        end
      end
    end
  end

  task automatic expect_state(input string tag);
    exp_q.push_back({m_lock, m_flags, m_wel});
    tag_q.push_back(tag);
    ->chk_ev;
    #2;
  endtask

  function automatic int lanes(input logic [1:0] md);
    return (md == 2'd1) ? 2 : (md == 2'd2) ? 4 : 1;
  endfunction

  // driver: sends one selection of nclk clocks, then deselects
  task automatic send(input logic [1:0] md, input logic [39:0] frame,
                      input int nclk, input logic [2:0] side_err,
                      input logic side_wren, input string tag);
    int w, full;
    w = lanes(md);
    full = 40 / w;
    mode = md;
    for (int i = 0; i < nclk; i++) begin
      @(negedge clk);
      cs_n = 1'b0;
      dq = 4'h0;
      for (int b = 0; b < w; b++) begin
        int idx;
        idx = 39 - i * w - b;
        dq[w-1-b] = (idx >= 0) ? frame[idx] : 1'b0;
      end
    end
    @(negedge clk);
    cs_n = 1'b1;
    err_set = side_err;
    wren_set = side_wren;
    @(negedge clk);
    err_set = 3'b000;
    wren_set = 1'b0;
    // reference model
    if (frame[39:32] == 8'hE5 && nclk == full && m_wel) begin
      m_lock = frame[7:0];
      m_wel = 1'b0;
    end
    if (frame[39:32] == 8'h50 && nclk * w >= 8) m_flags = 3'b000;
    m_flags = m_flags | side_err;
    if (side_wren) m_wel = 1'b1;
    expect_state(tag);
  endtask

  task automatic pulse(input logic [2:0] e, input logic wr, input string tag);
    @(negedge clk);
    err_set = e;
    wren_set = wr;
    @(negedge clk);
    err_set = 3'b000;
    wren_set = 1'b0;
    m_flags = m_flags | e;
    if (wr) m_wel = 1'b1;
    expect_state(tag);
  endtask

  function automatic logic [39:0] lockf(input logic [23:0] a, input logic [7:0] d);
    return {8'hE5, a, d};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_state("R10 reset");

    pulse(3'b000, 1'b1, "R9 wren");
    send(2'd0, lockf(24'h123456, 8'hA7), 40, 3'b000, 1'b0, "R2 x1 lock");
    send(2'd0, lockf(24'h000000, 8'h3C), 40, 3'b000, 1'b0, "R4 no wel");
    pulse(3'b000, 1'b1, "R9 wren again");
    send(2'd1, lockf(24'hFFFFFF, 8'h5B), 20, 3'b000, 1'b0, "R1 x2 lock");
    pulse(3'b000, 1'b1, "R9 wren x4");
    send(2'd2, lockf(24'hABCDEF, 8'hC3), 10, 3'b000, 1'b0, "R1 x4 lock");
    pulse(3'b000, 1'b1, "R9 wren short");
    send(2'd0, lockf(24'h0, 8'h11), 39, 3'b000, 1'b0, "R3 short x1");
    send(2'd2, lockf(24'h0, 8'h22), 11, 3'b000, 1'b0, "R3 long x4");
    send(2'd1, lockf(24'h0, 8'h33), 19, 3'b000, 1'b0, "R3 short x2");
    send(2'd3, lockf(24'h010203, 8'h96), 40, 3'b000, 1'b0, "R1 reserved mode");
    pulse(3'b001, 1'b0, "R8 erase flag");
    pulse(3'b010, 1'b0, "R8 program flag");
    pulse(3'b100, 1'b0, "R8 protection flag");
    send(2'd0, {8'h50, 32'h0}, 4, 3'b000, 1'b0, "R7 partial opcode");
    send(2'd1, {8'h50, 32'h0}, 4, 3'b000, 1'b0, "R6 clear x2");
    pulse(3'b111, 1'b0, "R8 all flags");
    send(2'd2, {8'h50, 32'hFFFF_FFFF}, 7, 3'b000, 1'b0, "R6 clear extra clocks");
    pulse(3'b011, 1'b0, "R8 set again");
    send(2'd0, {8'h50, 32'h0}, 8, 3'b010, 1'b0, "R8 set beats clear");
    pulse(3'b000, 1'b1, "R9 wren unknown");
    send(2'd0, {8'hA5, 24'h0, 8'h77}, 40, 3'b000, 1'b0, "R11 unknown opcode");
    send(2'd2, {8'hE5, 24'h0, 8'h6E}, 10, 3'b000, 1'b1, "R9 wren beats commit");
    send(2'd0, {8'hE4, 24'h0, 8'h44}, 40, 3'b000, 1'b0, "R11 near opcode");
    send(2'd2, lockf(24'h0, 8'h81), 10, 3'b000, 1'b0, "R5 commit clears wel");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end
endmodule